// File: doc/BRIEF.md
# PLL Divider and Multiplier Calculator

This block turns a wanted per-lane serial bit rate (in kbps) and the frequency of the reference clock feeding a PLL (in kHz) into a packed 16-bit PLL setup word. The word holds a pre-divider, a feedback multiplier and a frequency-band code. From that word the block then works out the frequency the PLL will actually produce. It also derives a 6-bit divider field for a low-power escape clock that must not exceed 10 MHz.

A host pulses `start` with both operands applied. The block runs for a few hundred cycles on one shared shift-subtract divider. It then pulses `done` and holds all results until the next completion. A zero reference frequency is refused at once with an error flag, and no division is attempted.

Top module: `pll_cfg_calc`

## Requirements
- R1: The pre-divider D starts at 1 and is raised by one while floor(ref / (D+1)) is at least 5000. The search stops at D = 31, so a successful result always has 1 <= D <= 31. D sits in word bits 12:8.
- R2: The multiplier M is ceil(rate × D / ref), computed without truncation of the product and saturated to 255. M sits in word bits 7:0.
- R3: The band code in word bits 15:14 comes from F = floor(ref × M / D). It is 3 when F >= 501000, 2 when F >= 251000, 1 when F >= 126000, and 0 otherwise.
- R4: Word bit 13 is always 0.
- R5: `pll_khz` equals floor(ref × M' / D'). Here M' and D' are the multiplier and divider fields read back from the word, and a field value of 0 is taken as 1.
- R6: `lp_div` equals (ceil(pll_khz / 80000) − 1) modulo 64.
- R7: When `ref_khz` is 0 at start, `done` pulses on the next cycle with `err` = 1 and `cfg_word`, `pll_khz` and `lp_div` all 0. Every other completion reports `err` = 0.
- R8: `done` is high for exactly one cycle per accepted start. `err`, `cfg_word`, `pll_khz` and `lp_div` change only in a cycle where `done` is high.
- R9: While `busy` is high, `start` is ignored. The running calculation keeps its operands and produces exactly one result.
- R10: After reset, `busy`, `done` and `err` are 0, and `cfg_word`, `pll_khz` and `lp_div` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation; taken only while idle |
| rate_kbps | input | 32 | Wanted per-lane bit rate in kbps |
| ref_khz | input | 32 | Reference clock frequency in kHz |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| err | output | 1 | Last result was refused for a zero reference |
| cfg_word | output | 16 | Packed band / divider / multiplier word |
| pll_khz | output | 40 | Decoded PLL output frequency in kHz |
| lp_div | output | 6 | Low-power clock divider field |

## Verification
The assertions take for granted that the host presents operands only together with `start` while `busy` is low. They also take for granted that the internal divider is never handed a zero denominator, because the zero-reference case is diverted before any division. The stimulus stays within these limits by waiting for `busy` to drop before each new job, and by using rates small enough that rate × D stays far below the 40-bit datapath. One stray start pulse is sent on purpose in the middle of a busy calculation. It carries a zero reference, so if the block accepted it, the result would show up as an error.

// File: rtl/pllc_pkg.sv
package pllc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SEARCH = 3'd1,
        ST_MUL    = 3'd2,
        ST_FREQ   = 3'd3,
        ST_DEC    = 3'd4,
        ST_LP     = 3'd5
    } calc_state_e;

endpackage

// File: rtl/pllc_divsearch.sv
module pllc_divsearch #(
    parameter int unsigned IN_W  = 32,
    parameter int unsigned DIV_W = 5,
    parameter int unsigned STEP  = 5000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [IN_W-1:0]  ref_i,
    output logic             done,
    output logic [DIV_W-1:0] div_o
);
    localparam int unsigned TW = IN_W + DIV_W + 1;
    localparam logic [DIV_W-1:0] DMAX = DIV_W'((1 << DIV_W) - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [DIV_W-1:0] div;
        logic [TW-1:0]    thr;
    } srch_t;

    srch_t q, d;
    logic [TW-1:0] ref_w;

    assign ref_w = TW'(ref_i);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (go) begin
            d.busy = 1'b1;
            d.div  = DIV_W'(1);
            d.thr  = TW'(2 * STEP);
        end else if (q.busy) begin
            if (q.div == DMAX || ref_w < q.thr) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.div = q.div + DIV_W'(1);
                d.thr = q.thr + TW'(STEP);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done  = q.done;
    assign div_o = q.div;

    AST_SEARCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (div_o == DIV_W'(1) || ref_w >= TW'(STEP) * TW'(div_o))); // R1

endmodule

// File: rtl/pllc_seqdiv.sv
module pllc_seqdiv #(
    parameter int unsigned NUM_W = 40,
    parameter int unsigned DEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done,
    output logic [NUM_W-1:0] quo_o,
    output logic [DEN_W-1:0] rem_o
);
    localparam int unsigned CW = $clog2(NUM_W);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CW-1:0]    cnt;
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] dq;
        logic [DEN_W-1:0] den;
    } sdiv_t;

    sdiv_t q, d;
    logic [DEN_W:0] trial;
    logic [DEN_W:0] diff;
    logic           ge;

    assign trial = {q.rem, q.dq[NUM_W-1]};
    assign ge    = trial >= {1'b0, q.den};
    assign diff  = trial - {1'b0, q.den};

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (go) begin
            d.busy = 1'b1;
            d.cnt  = '0;
            d.rem  = '0;
            d.dq   = num_i;
            d.den  = den_i;
        end else if (q.busy) begin
            d.rem = ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
            d.dq  = {q.dq[NUM_W-2:0], ge};
            if (q.cnt == CW'(NUM_W - 1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done  = q.done;
    assign quo_o = q.dq;
    assign rem_o = q.rem;

    AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rem_o < q.den); // R2

endmodule

// File: rtl/pllc_range.sv
module pllc_range #(
    parameter int unsigned W    = 40,
    parameter int unsigned LIM1 = 126000,
    parameter int unsigned LIM2 = 251000,
    parameter int unsigned LIM3 = 501000
) (
    input  logic [W-1:0] freq_i,
    output logic [1:0]   code_o
);
    always_comb begin
        if (freq_i >= W'(LIM3))      code_o = 2'd3;
        else if (freq_i >= W'(LIM2)) code_o = 2'd2;
        else if (freq_i >= W'(LIM1)) code_o = 2'd1;
        else                         code_o = 2'd0;
    end
endmodule

// File: rtl/pll_cfg_calc.sv
module pll_cfg_calc
    import pllc_pkg::*;
#(
    parameter int unsigned IN_W     = 32,
    parameter int unsigned DIV_W    = 5,
    parameter int unsigned MUL_W    = 8,
    parameter int unsigned LP_W     = 6,
    parameter int unsigned REF_STEP = 5000,
    parameter int unsigned LP_STEP  = 80000,
    parameter int unsigned BAND1    = 126000,
    parameter int unsigned BAND2    = 251000,
    parameter int unsigned BAND3    = 501000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [IN_W-1:0]          rate_kbps,
    input  logic [IN_W-1:0]          ref_khz,
    output logic                     busy,
    output logic                     done,
    output logic                     err,
    output logic [MUL_W+DIV_W+2:0]   cfg_word,
    output logic [IN_W+MUL_W-1:0]    pll_khz,
    output logic [LP_W-1:0]          lp_div
);
    localparam int unsigned PROD_W  = IN_W + MUL_W;
    localparam int unsigned CFG_W   = MUL_W + DIV_W + 3;
    localparam int unsigned MUL_MAX = (1 << MUL_W) - 1;

    typedef struct packed {
        calc_state_e       st;
        logic [IN_W-1:0]   rate;
        logic [IN_W-1:0]   refk;
        logic [DIV_W-1:0]  div;
        logic [MUL_W-1:0]  mul;
        logic [1:0]        rng;
        logic [PROD_W-1:0] pll;
        logic              ds_go;
        logic              dv_go;
        logic [PROD_W-1:0] dv_num;
        logic [IN_W-1:0]   dv_den;
        logic              done;
        logic              err;
        logic [CFG_W-1:0]  word;
        logic [PROD_W-1:0] pll_o;
        logic [LP_W-1:0]   lp_o;
    } calc_t;

    calc_t q, d;

    logic              ds_done;
    logic [DIV_W-1:0]  ds_div;
    logic              dv_done;
    logic [PROD_W-1:0] dv_quo;
    logic [IN_W-1:0]   dv_rem;
    logic [1:0]        rng_now;
    logic [PROD_W-1:0] ceil_q;
    logic [MUL_W-1:0]  mul_sat;
    logic [MUL_W-1:0]  mul_dec;
    logic [DIV_W-1:0]  div_dec;
    logic [PROD_W-1:0] lp_m1;

    pllc_divsearch #(.IN_W(IN_W), .DIV_W(DIV_W), .STEP(REF_STEP)) u_search (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (q.ds_go),
        .ref_i (q.refk),
        .done  (ds_done),
        .div_o (ds_div)
    );

    pllc_seqdiv #(.NUM_W(PROD_W), .DEN_W(IN_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (q.dv_go),
        .num_i (q.dv_num),
        .den_i (q.dv_den),
        .done  (dv_done),
        .quo_o (dv_quo),
        .rem_o (dv_rem)
    );

    pllc_range #(.W(PROD_W), .LIM1(BAND1), .LIM2(BAND2), .LIM3(BAND3)) u_band (
        .freq_i (dv_quo),
        .code_o (rng_now)
    );

    assign ceil_q  = dv_quo + PROD_W'(dv_rem != '0);
    assign mul_sat = (ceil_q > PROD_W'(MUL_MAX)) ? MUL_W'(MUL_MAX) : ceil_q[MUL_W-1:0];
    assign mul_dec = (q.mul == '0) ? MUL_W'(1) : q.mul;
    assign div_dec = (q.div == '0) ? DIV_W'(1) : q.div;
    assign lp_m1   = ceil_q - PROD_W'(1);

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.ds_go = 1'b0;
        d.dv_go = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    if (ref_khz == '0) begin
                        d.err   = 1'b1;
                        d.done  = 1'b1;
                        d.word  = '0;
                        d.pll_o = '0;
                        d.lp_o  = '0;
                    end else begin
                        d.rate  = rate_kbps;
                        d.refk  = ref_khz;
                        d.ds_go = 1'b1;
                        d.st    = ST_SEARCH;
                    end
                end
            end
            ST_SEARCH: begin
                if (ds_done) begin
                    d.div    = ds_div;
                    d.dv_num = PROD_W'(q.rate) * PROD_W'(ds_div);
                    d.dv_den = q.refk;
                    d.dv_go  = 1'b1;
                    d.st     = ST_MUL;
                end
            end
            ST_MUL: begin
                if (dv_done) begin
                    d.mul    = mul_sat;
                    d.dv_num = PROD_W'(q.refk) * PROD_W'(mul_sat);
                    d.dv_den = IN_W'(q.div);
                    d.dv_go  = 1'b1;
                    d.st     = ST_FREQ;
                end
            end
            ST_FREQ: begin
                if (dv_done) begin
                    d.rng    = rng_now;
                    d.dv_num = PROD_W'(q.refk) * PROD_W'(mul_dec);
                    d.dv_den = IN_W'(div_dec);
                    d.dv_go  = 1'b1;
                    d.st     = ST_DEC;
                end
            end
            ST_DEC: begin
                if (dv_done) begin
                    d.pll    = dv_quo;
                    d.dv_num = dv_quo;
                    d.dv_den = IN_W'(LP_STEP);
                    d.dv_go  = 1'b1;
                    d.st     = ST_LP;
                end
            end
            ST_LP: begin
                if (dv_done) begin
                    d.word  = {q.rng, 1'b0, q.div, q.mul};
                    d.pll_o = q.pll;
                    d.lp_o  = lp_m1[LP_W-1:0];
                    d.err   = 1'b0;
                    d.done  = 1'b1;
                    d.st    = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;
    assign err      = q.err;
    assign cfg_word = q.word;
    assign pll_khz  = q.pll_o;
    assign lp_div   = q.lp_o;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(cfg_word) && $stable(pll_khz) && $stable(lp_div) && $stable(err))); // R8
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (cfg_word == '0 && pll_khz == '0 && lp_div == '0)); // R7
    AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(q.refk) && $stable(q.rate))); // R9
    AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (cfg_word[MUL_W +: DIV_W] != '0)); // R1
    AST_PLL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (pll_khz != '0)); // R5
    AST_BIT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cfg_word[MUL_W + DIV_W]); // R4

endmodule

// File: tb/pll_cfg_calc_test.sv
module pll_cfg_calc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] rate_kbps = '0;
    logic [31:0] ref_khz = '0;
    logic        busy, done, err;
    logic [15:0] cfg_word;
    logic [39:0] pll_khz;
    logic [5:0]  lp_div;

    int checks = 0;
    int failures = 0;

    typedef struct {
        bit          err;
        logic [15:0] word;
        logic [39:0] pll;
        logic [5:0]  lp;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    pll_cfg_calc uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rate_kbps(rate_kbps), .ref_khz(ref_khz),
        .busy(busy), .done(done), .err(err),
        .cfg_word(cfg_word), .pll_khz(pll_khz), .lp_div(lp_div)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic exp_t model(longint unsigned rate, longint unsigned rf, string tag);
        exp_t e;
        longint unsigned dv, m, f, md, p, n, rng;
        e.tag = tag;
        if (rf == 0) begin
            e.err = 1'b1; e.word = '0; e.pll = '0; e.lp = '0;
            return e;
        end
        dv = 1;
        while (dv < 31 && rf / (dv + 1) >= 5000) dv++;
        m = (rate * dv + rf - 1) / rf;
        if (m > 255) m = 255;
        f = rf * m / dv;
        rng = (f >= 501000) ? 3 : (f >= 251000) ? 2 : (f >= 126000) ? 1 : 0;
        e.word = 16'((rng << 14) | (dv << 8) | m);
        md = (m == 0) ? 1 : m;
        p = rf * md / dv;
        n = (p + 79999) / 80000;
        e.pll = 40'(p);
        e.lp = 6'((n - 1) & 63);
        e.err = 1'b0;
        return e;
    endfunction

    bit prev_done = 1'b0;

    always @(negedge clk) begin
        if (prev_done) chk(!done, "R8", "done pulse width", done, 0);
        if (done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(err == e.err, (e.err ? "R7" : e.tag), "err", err, e.err);
                chk(cfg_word == e.word, e.tag, "cfg_word", cfg_word, e.word);
                chk(pll_khz == e.pll, (e.err ? "R7" : "R5"), "pll_khz", pll_khz, e.pll);
                chk(lp_div == e.lp, (e.err ? "R7" : "R6"), "lp_div", lp_div, e.lp);
            end
        end
        prev_done = done;
    end

    task automatic run_job(input logic [31:0] rate, input logic [31:0] rf,
                           input string tag, input bit poke);
        while (busy) @(negedge clk);
        sb.push_back(model(rate, rf, tag));
        start = 1'b1; rate_kbps = rate; ref_khz = rf;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            chk(busy == 1'b1, "R9", "busy during stray start", busy, 1);
            start = 1'b1; rate_kbps = 32'd7; ref_khz = 32'd0;
            @(negedge clk);
            start = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R8", "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle state after reset
        chk(busy == 0 && done == 0 && err == 0, "R10", "control outputs", {busy, done, err}, 0);
        chk(cfg_word == 0 && pll_khz == 0 && lp_div == 0, "R10", "result outputs", cfg_word, 0);

        run_job(32'd1000, 32'd0, "R7", 1'b0);
        run_job(32'd500000, 32'd27000, "R3", 1'b0);
        run_job(32'd100000, 32'd9999, "R1", 1'b0);
        run_job(32'd100000, 32'd10000, "R1", 1'b0);
        run_job(32'd300000, 32'd154999, "R1", 1'b0);
        run_job(32'd300000, 32'd155000, "R1", 1'b0);
        run_job(32'd900000, 32'd400000, "R1", 1'b0);
        run_job(32'd1000000, 32'd1000, "R2", 1'b0);
        run_job(32'd125001, 32'd1000, "R2", 1'b0);
        run_job(32'd125000, 32'd1000, "R3", 1'b0);
        run_job(32'd126000, 32'd1000, "R3", 1'b0);
        run_job(32'd250000, 32'd1000, "R3", 1'b0);
        run_job(32'd251000, 32'd1000, "R3", 1'b0);
        run_job(32'd498000, 32'd3000, "R3", 1'b0);
        run_job(32'd501000, 32'd3000, "R3", 1'b0);
        run_job(32'd0, 32'd27000, "R5", 1'b0);
        run_job(32'd80000, 32'd80000, "R4", 1'b0);
        run_job(32'd80001, 32'd80000, "R4", 1'b0);
        run_job(32'd480000, 32'd19200, "R9", 1'b1);
        run_job(32'd5, 32'd0, "R7", 1'b0);
        run_job(32'd400000, 32'd24000, "R2", 1'b0);

        // R8: results held after the last completion
        chk(err == 0 && cfg_word == model(400000, 24000, "R8").word, "R8", "held word",
            cfg_word, model(400000, 24000, "R8").word);
        finish_run();
    end

endmodule